// File: doc/BRIEF.md
# Keypad Device-Code Entry Controller

This block sits between a keypad decoder and an emulation datapath. It takes single key events (ten digits, an ENTER key and a QUIT key) and collects up to three decimal digits into a device code. On ENTER it converts the digits to binary and range-checks the value. It then looks the value up in a per-code availability bitmap. A code that is missing, zero or too large raises an error flag and the block returns to code entry.

A code that is present first produces a one-cycle announcement strobe, so a display can show the device. Emulation mode follows: the enable stays high and the selected code is held on the select output until QUIT is pressed. The availability bitmap is filled through a simple single-bit write port.

Key events use a valid/ready handshake. An event is taken on a clock edge where `key_valid` and `key_ready` are both high. `key_ready` drops for the two cycles of the lookup and announcement. A source holding `key_valid` during those cycles must keep `key_code` stable until the event is accepted.

Top module: `devsel_keypad_ctrl`

## Requirements
- R1: After reset `emu_en`, `info_pulse` and `code_err` are low, `sel_code` is zero, `key_ready` is high and every bitmap entry reads as absent.
- R2: `key_code` values 0 to 9 are digits, 10 is ENTER, 11 is QUIT; values 12 to 15 are accepted but change neither the digits collected nor the mode.
- R3: `key_ready` is low in the first cycle after an in-range ENTER (lookup) and in the announcement cycle; it is high in entry and emulation modes.
- R4: Digits build the value in decimal with the first digit most significant; a fourth or later digit before ENTER or QUIT is ignored.
- R5: ENTER after fewer than three digits uses the value of the digits typed so far; ENTER with no digits gives the value 0.
- R6: A value of 0 or above 255 sets `code_err` in the cycle after ENTER; the block stays in entry mode with the digits cleared.
- R7: A cycle with `map_wr_en` high stores `map_wr_bit` as the availability of code `map_wr_addr`; 1 means present.
- R8: An in-range code whose bitmap bit is 0 sets `code_err` two cycles after ENTER, and entry mode resumes with the digits cleared.
- R9: An in-range code whose bitmap bit is 1 gives `info_pulse` for exactly the second cycle after ENTER; from the third cycle `emu_en` is high and `sel_code` equals the code.
- R10: In emulation mode digits and ENTER are ignored; QUIT drops `emu_en` in the cycle after it and returns to entry mode with the digits cleared.
- R11: QUIT in entry mode clears the digits collected and sets no error.
- R12: `code_err` clears in the cycle after any accepted key event other than a failing ENTER.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | A key event is offered |
| key_code | input | 4 | Key: 0-9 digit, 10 ENTER, 11 QUIT |
| key_ready | output | 1 | Block can accept a key event |
| map_wr_en | input | 1 | Write one bitmap entry |
| map_wr_addr | input | 8 | Code whose entry is written |
| map_wr_bit | input | 1 | 1 marks the code present |
| code_err | output | 1 | Last entered code was rejected |
| info_pulse | output | 1 | One-cycle strobe announcing the chosen device |
| emu_en | output | 1 | Emulation mode active |
| sel_code | output | 8 | Selected code while `emu_en` is high, else 0 |

## Verification
On every cycle the assertions check the ordering around the announcement, namely single-cycle strobe, emulation directly after it and never without it. They also check that emulation persists until QUIT and ends right after it, that the handshake is closed during the announcement, that the error flag clears after an ordinary key, and that a live selection is never code zero. The decimal conversion and the fourth-digit cut-off cannot be seen by a property over ports. Neither can the range limits or the bitmap contents deciding between found and not found. The bench scenarios show these by comparing each ENTER against a value computed from the digits typed and a bench copy of the bitmap.

// File: rtl/devsel_pkg.sv
package devsel_pkg;
  typedef enum logic [1:0] {
    ST_ENTRY   = 2'd0,
    ST_LOOKUP  = 2'd1,
    ST_ANNOUNCE = 2'd2,
    ST_EMULATE = 2'd3
  } entry_state_t;

  localparam logic [3:0] KEY_ENTER = 4'd10;
  localparam logic [3:0] KEY_QUIT  = 4'd11;
  localparam logic [3:0] KEY_MAXDIGIT = 4'd9;
endpackage

// File: rtl/digit_accum.sv
module digit_accum #(
  parameter int NDIG  = 3,
  parameter int ACC_W = 10,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [3:0]       digit,
  output logic [ACC_W-1:0] value
);
  localparam int WIDE_W = ACC_W + 4;

  logic [CNT_W-1:0]  count_q;
  logic [WIDE_W-1:0] scaled;
  logic              room;

  always_comb begin
    scaled = {4'b0, value} * WIDE_W'(10) + WIDE_W'(digit);
    room   = (count_q < CNT_W'(NDIG));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      value   <= '0;
      count_q <= '0;
    end else if (push && room) begin
      value   <= scaled[ACC_W-1:0];
      count_q <= count_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/dev_bitmap.sv
module dev_bitmap #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic [CODE_W-1:0] rd_addr,
  output logic              rd_hit
);
  localparam int DEPTH = 1 << CODE_W;

  logic [DEPTH-1:0] present_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        present_q[i] <= 1'b0;
      else if (wr_en && (wr_addr == CODE_W'(i)))
        present_q[i] <= wr_bit;
    end
  end

  assign rd_hit = present_q[rd_addr];
endmodule

// File: rtl/entry_fsm.sv
module entry_fsm
  import devsel_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int ACC_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_fire,
  input  logic [3:0]        key_code,
  input  logic [ACC_W-1:0]  acc_value,
  input  logic              map_hit,
  output entry_state_t      state,
  output logic [CODE_W-1:0] code_q,
  output logic              err_q,
  output logic              acc_clr,
  output logic              acc_push,
  output logic              key_ready
);
  localparam int MAX_CODE = (1 << CODE_W) - 1;

  logic is_digit, is_enter, is_quit, in_range;

  always_comb begin
    is_digit  = key_code <= KEY_MAXDIGIT;
    is_enter  = key_code == KEY_ENTER;
    is_quit   = key_code == KEY_QUIT;
    in_range  = (acc_value != '0) && (acc_value <= ACC_W'(MAX_CODE));
    key_ready = (state == ST_ENTRY) || (state == ST_EMULATE);
    acc_push  = key_fire && (state == ST_ENTRY) && is_digit;
    acc_clr   = key_fire && (((state == ST_ENTRY) && (is_enter || is_quit)) ||
                             ((state == ST_EMULATE) && is_quit));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_ENTRY;
      code_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (key_fire) err_q <= 1'b0;
      unique case (state)
        ST_ENTRY: begin
          if (key_fire && is_enter) begin
            if (in_range) begin
              code_q <= acc_value[CODE_W-1:0];
              state  <= ST_LOOKUP;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_LOOKUP: begin
          if (map_hit) begin
            state <= ST_ANNOUNCE;
          end else begin
            err_q <= 1'b1;
            state <= ST_ENTRY;
          end
        end
        ST_ANNOUNCE: state <= ST_EMULATE;
        ST_EMULATE: begin
          if (key_fire && is_quit) begin
            state  <= ST_ENTRY;
            code_q <= '0;
          end
        end
        default: state <= ST_ENTRY;
      endcase
    end
  end
endmodule

// File: rtl/devsel_keypad_ctrl.sv
module devsel_keypad_ctrl
  import devsel_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int NDIG   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [3:0]        key_code,
  output logic              key_ready,
  input  logic              map_wr_en,
  input  logic [CODE_W-1:0] map_wr_addr,
  input  logic              map_wr_bit,
  output logic              code_err,
  output logic              info_pulse,
  output logic              emu_en,
  output logic [CODE_W-1:0] sel_code
);
  localparam int ACC_W = $clog2(10 ** NDIG);
  localparam int CNT_W = $clog2(NDIG + 1);

  entry_state_t      state;
  logic [CODE_W-1:0] code_q;
  logic [ACC_W-1:0]  acc_value;
  logic              acc_clr, acc_push, map_hit, key_fire;

  assign key_fire = key_valid && key_ready;

  digit_accum #(.NDIG(NDIG), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (acc_clr),
    .push  (acc_push),
    .digit (key_code),
    .value (acc_value)
  );

  dev_bitmap #(.CODE_W(CODE_W)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (map_wr_en),
    .wr_addr (map_wr_addr),
    .wr_bit  (map_wr_bit),
    .rd_addr (code_q),
    .rd_hit  (map_hit)
  );

  entry_fsm #(.CODE_W(CODE_W), .ACC_W(ACC_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_fire  (key_fire),
    .key_code  (key_code),
    .acc_value (acc_value),
    .map_hit   (map_hit),
    .state     (state),
    .code_q    (code_q),
    .err_q     (code_err),
    .acc_clr   (acc_clr),
    .acc_push  (acc_push),
    .key_ready (key_ready)
  );

  assign info_pulse = (state == ST_ANNOUNCE);
  assign emu_en     = (state == ST_EMULATE);
  assign sel_code   = emu_en ? code_q : '0;
endmodule

// File: rtl/devsel_keypad_ctrl_chk.sv
module devsel_keypad_ctrl_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              key_valid,
  input logic [3:0]        key_code,
  input logic              key_ready,
  input logic              code_err,
  input logic              info_pulse,
  input logic              emu_en,
  input logic [CODE_W-1:0] sel_code
);
  logic fire, quit_fire;
  assign fire      = key_valid && key_ready;
  assign quit_fire = fire && (key_code == 4'd11);

  p_show_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    info_pulse |=> !info_pulse);
  p_show_then_emu_r9: assert property (@(posedge clk) disable iff (!rst_n)
    info_pulse |=> emu_en);
  p_emu_needs_show_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(emu_en) |-> $past(info_pulse));
  p_emu_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_en && !quit_fire) |=> emu_en);
  p_quit_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_en && quit_fire) |=> !emu_en);
  p_busy_show_r3: assert property (@(posedge clk) disable iff (!rst_n)
    info_pulse |-> !key_ready);
  p_sel_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    emu_en |-> (sel_code != '0));
  p_err_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && key_code != 4'd10) |=> !code_err);
  p_no_err_emu_r8: assert property (@(posedge clk) disable iff (!rst_n)
    emu_en |-> !code_err);
endmodule

bind devsel_keypad_ctrl devsel_keypad_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .key_valid  (key_valid),
  .key_code   (key_code),
  .key_ready  (key_ready),
  .code_err   (code_err),
  .info_pulse (info_pulse),
  .emu_en     (emu_en),
  .sel_code   (sel_code)
);

// File: tb/sim_devsel_keypad_ctrl.sv
module sim_devsel_keypad_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 8;

  typedef int dig_t[4];

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              key_valid = 1'b0;
  logic [3:0]        key_code = '0;
  logic              key_ready;
  logic              map_wr_en = 1'b0;
  logic [CODE_W-1:0] map_wr_addr = '0;
  logic              map_wr_bit = 1'b0;
  logic              code_err, info_pulse, emu_en;
  logic [CODE_W-1:0] sel_code;

  bit model_map[256];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  devsel_keypad_ctrl #(.CODE_W(CODE_W), .NDIG(3)) u0 (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
    .key_ready(key_ready), .map_wr_en(map_wr_en), .map_wr_addr(map_wr_addr),
    .map_wr_bit(map_wr_bit), .code_err(code_err), .info_pulse(info_pulse),
    .emu_en(emu_en), .sel_code(sel_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int fold(dig_t d, int n);
    int v = 0;
    for (int i = 0; i < n && i < 3; i++) v = v * 10 + d[i];
    return v;
  endfunction

  task automatic press(input logic [3:0] c);
    while (!key_ready) @(negedge clk);
    key_valid = 1'b1;
    key_code  = c;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic wr_map(input int addr, input bit b);
    map_wr_en = 1'b1;
    map_wr_addr = CODE_W'(addr);
    map_wr_bit = b;
    @(negedge clk);
    map_wr_en = 1'b0;
    model_map[addr] = b;
  endtask

  // Presses ENTER and checks the outcome for expected value v.
  task automatic finish_enter(input int v, input bit poke_in_emu);
    press(4'd10);
    if (v == 0 || v > 255) begin
      check(code_err == 1'b1, "R6 err after bad code", code_err, 1);
      check(emu_en == 1'b0 && key_ready == 1'b1, "R6 stays in entry", emu_en, 0);
      return;
    end
    check(key_ready == 1'b0, "R3 ready low in lookup", key_ready, 0);
    check(code_err == 1'b0, "R12 err clear after ENTER", code_err, 0);
    @(negedge clk);
    if (!model_map[v]) begin
      check(code_err == 1'b1, "R8 err on absent code", code_err, 1);
      check(info_pulse == 1'b0 && emu_en == 1'b0, "R8 no announce", info_pulse, 0);
      return;
    end
    check(info_pulse == 1'b1 && code_err == 1'b0, "R9 announce strobe", info_pulse, 1);
    check(key_ready == 1'b0, "R3 ready low in announce", key_ready, 0);
    @(negedge clk);
    check(info_pulse == 1'b0, "R9 strobe one cycle", info_pulse, 0);
    check(emu_en == 1'b1, "R9 emulation on", emu_en, 1);
    check(sel_code == CODE_W'(v), "R9 selected code", sel_code, v);
    if (poke_in_emu) begin
      press(4'd5);
      check(emu_en == 1'b1 && sel_code == CODE_W'(v), "R10 digit ignored in emulation", sel_code, v);
      press(4'd10);
      check(emu_en == 1'b1 && sel_code == CODE_W'(v), "R10 ENTER ignored in emulation", sel_code, v);
    end
    press(4'd11);
    check(emu_en == 1'b0, "R10 QUIT ends emulation", emu_en, 0);
    check(sel_code == '0 && key_ready == 1'b1, "R10 back to entry", sel_code, 0);
  endtask

  task automatic run_code(input dig_t d, input int n, input bit poke);
    for (int i = 0; i < n; i++) press(4'(d[i]));
    finish_enter(fold(d, n), poke);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    dig_t d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(emu_en == 0 && info_pulse == 0 && code_err == 0, "R1 reset outputs", emu_en, 0);
    check(sel_code == 0 && key_ready == 1, "R1 reset select/ready", sel_code, 0);
    // R1/R8: empty bitmap, code 123 absent
    d = '{1, 2, 3, 0};
    run_code(d, 3, 0);
    // R7: mark 123 present, then found
    wr_map(123, 1);
    run_code(d, 3, 1);
    // R12: error cleared by a digit
    wr_map(123, 0);
    run_code(d, 3, 0);
    press(4'd4);
    check(code_err == 0, "R12 digit clears err", code_err, 0);
    // R11: QUIT in entry clears digits (4 discarded), value becomes 9
    wr_map(9, 1);
    press(4'd11);
    check(code_err == 0 && emu_en == 0, "R11 QUIT in entry no err", code_err, 0);
    press(4'd9);
    finish_enter(9, 0);
    // R4: fourth digit ignored -> 123
    wr_map(123, 1);
    d = '{1, 2, 3, 9};
    run_code(d, 4, 0);
    // R5: short entry, single digit 7
    wr_map(7, 1);
    d = '{7, 0, 0, 0};
    run_code(d, 1, 0);
    // R5/R6: ENTER with no digits -> 0
    run_code(d, 0, 0);
    // R6: 256 and 000 rejected; 255 accepted
    d = '{2, 5, 6, 0};
    run_code(d, 3, 0);
    d = '{0, 0, 0, 0};
    run_code(d, 3, 0);
    wr_map(255, 1);
    d = '{2, 5, 5, 0};
    run_code(d, 3, 1);
    // R2: key 13 is ignored between digits -> 12
    wr_map(12, 1);
    press(4'd1); press(4'd13); press(4'd2);
    finish_enter(12, 0);
    // random map contents
    for (int i = 0; i < 256; i++) wr_map(i, bit'($urandom_range(0, 1)));
    for (int t = 0; t < 250; t++) begin
      int n = $urandom_range(0, 4);
      if ($urandom_range(0, 3) == 0) wr_map($urandom_range(0, 255), bit'($urandom_range(0, 1)));
      for (int i = 0; i < 4; i++) d[i] = $urandom_range(0, 9);
      if ($urandom_range(0, 1) == 1) d[0] = $urandom_range(0, 2);
      run_code(d, n, bit'($urandom_range(0, 1)));
    end
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule